// File: doc/BRIEF.md
# Dual-Channel Streaming Read Engine

The engine pulls a run of items from an external device into a local read queue without processor involvement. Software configures each of its two channels by writing an item size and a start address. It then writes a nonzero item count, and the engine issues one read after another on a simple memory-side port. Each returned item is zero-extended to a 32-bit word and placed in the queue. Software takes words from the head of the queue and watches the queue occupancy and the per-channel outstanding counts.

The two channels can be used alternately for continuous streaming: one is refilled while the other runs. A single channel can also be used alone. Each channel keeps its next address after a run ends, so a new count written without reconfiguring continues the sequence. Writing a zero count abandons the run on that channel. When the queue is full the engine stops issuing reads, and it restarts by itself once a word is removed.

The memory port is a request/ready handshake. The engine holds `mem_req` together with a stable address and size until `mem_ready` is high. Data on `mem_rdata` is taken in the cycle in which both are high.

Top module: `nbrd_engine`

## Requirements
- R1: After reset both outstanding counts read 0, queue occupancy reads 0 and `mem_req` is low.
- R2: Writing a count N from 1 to 4095 to a channel starts N reads on that channel. The first read uses the configured address, and the count read back drops by one for every item placed in the queue.
- R3: Size code 0 selects 8-bit items and steps the address by 1. Code 1 selects 16-bit items and steps by 2. Codes 2 and 3 select 32-bit items and step by 4. Addresses are 29 bits wide and wrap modulo 2^29.
- R4: An 8-bit or 16-bit item enters the queue as `mem_rdata[7:0]` or `mem_rdata[15:0]`, with all higher bits zero. A 32-bit item enters unchanged.
- R5: No read is launched while the queue holds DEPTH words. Issuing resumes without software action after a word is popped, and continues until the count reaches 0.
- R6: A channel's size and next address survive the end of a run or a cancel. A new count written without a configuration write continues from the address that follows the last item placed in the queue.
- R7: Writing count 0 to a channel makes its count read 0 on the next cycle, and no further read is launched for that channel.
- R8: While channel 0 has a nonzero count, no read is launched for channel 1. If both channels hold work, channel 0 runs to completion first.
- R9: A count or configuration write to the channel whose read is in flight discards that read's data, including a write that lands in the same cycle as the response. No word is pushed, the address does not advance, and the written value takes effect.
- R10: The queue returns words in the order they were pushed. Occupancy equals pushes minus pops, and a pop of an empty queue is ignored.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr` and `mem_size` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel targeted by the configuration write |
| cfg_size | input | 2 | Item size code (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| cfg_addr | input | AW | Start address, relative to the device |
| cnt_we | input | 1 | Count write strobe (nonzero starts, zero cancels) |
| cnt_ch | input | 1 | Channel targeted by the count write |
| cnt_val | input | CW | Item count to load |
| cnt0_left | output | CW | Items outstanding on channel 0 |
| cnt1_left | output | CW | Items outstanding on channel 1 |
| mem_req | output | 1 | Read request to the device |
| mem_addr | output | AW | Address of the requested item |
| mem_size | output | 2 | Size code of the requested item |
| mem_ready | input | 1 | Device returns data this cycle |
| mem_rdata | input | 32 | Returned data, taken when `mem_req` and `mem_ready` are both high |
| fifo_pop | input | 1 | Remove the head word |
| fifo_data | output | 32 | Head word of the queue |
| fifo_level | output | LW | Number of words in the queue |

## Verification
The hard case is a read response that completes on the same edge as a software count write to the channel that owns the read. The bench holds `mem_ready` low so that the request stays pending. It then schedules the release of `mem_ready` for the exact cycle in which it drives a restart count onto that channel. The outcome is judged at the ports: the queue must stay empty and the count must show the new value. The refetch must then come from the unadvanced address, followed by the full new run in order.

// File: rtl/nbrd_pkg.sv
package nbrd_pkg;

  localparam int NCH = 2;
  localparam int DW  = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } item_size_e;

  // Address step in bytes for a given size code.
  function automatic logic [2:0] step_of(input logic [1:0] sz);
    case (item_size_e'(sz))
      SZ_BYTE: step_of = 3'd1;
      SZ_HALF: step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction

  // Keep only the bytes belonging to the item.
  function automatic logic [DW-1:0] zext(input logic [DW-1:0] d, input logic [1:0] sz);
    case (item_size_e'(sz))
      SZ_BYTE: zext = {{(DW-8){1'b0}},  d[7:0]};
      SZ_HALF: zext = {{(DW-16){1'b0}}, d[15:0]};
      default: zext = d;
    endcase
  endfunction

endpackage

// File: rtl/nbrd_chan.sv
module nbrd_chan
  import nbrd_pkg::*;
#(
  parameter int AW = 29,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_hit,
  input  logic [1:0]    cfg_size,
  input  logic [AW-1:0] cfg_addr,
  input  logic          cnt_hit,
  input  logic [CW-1:0] cnt_val,
  input  logic          item_done,
  output logic [1:0]    size_q,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] left_q
);

  logic [AW-1:0] addr_next;
  assign addr_next = addr_q + AW'(step_of(size_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= SZ_BYTE;
      addr_q <= '0;
    end else if (cfg_hit) begin
      size_q <= cfg_size;
      addr_q <= cfg_addr;
    end else if (item_done) begin
      addr_q <= addr_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      left_q <= '0;
    else if (cnt_hit)
      left_q <= cnt_val;
    else if (item_done && left_q != '0)
      left_q <= left_q - CW'(1);
  end

endmodule

// File: rtl/nbrd_issue.sv
module nbrd_issue
  import nbrd_pkg::*;
#(
  parameter int AW    = 29,
  parameter int CW    = 12,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CW-1:0]         left   [NCH],
  input  logic [AW-1:0]         addr   [NCH],
  input  logic [1:0]            size   [NCH],
  input  logic [NCH-1:0]        hit,
  input  logic [LW-1:0]         fifo_level,
  input  logic                  mem_ready,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  mem_req,
  output logic [AW-1:0]         mem_addr,
  output logic [1:0]            mem_size,
  output logic                  push,
  output logic [DW-1:0]         push_data,
  output logic [NCH-1:0]        done,
  output logic [$clog2(NCH)-1:0] req_ch
);

  localparam int CHW = $clog2(NCH);

  logic           busy_q, kill_q;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  addr_rq;
  logic [1:0]     size_rq;

  logic [CHW-1:0] pick;
  logic           found, room, launch, resp, accept;

  // Lowest-numbered channel with work wins.
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (left[i] != '0) begin
        pick  = CHW'(i);
        found = 1'b1;
      end
    end
  end

  assign room   = fifo_level < LW'(DEPTH);
  assign launch = !busy_q && found && !hit[pick] && room;
  assign resp   = busy_q && mem_ready;
  assign accept = resp && !kill_q && !hit[ch_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      kill_q  <= 1'b0;
      ch_q    <= '0;
      addr_rq <= '0;
      size_rq <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      kill_q  <= 1'b0;
      ch_q    <= pick;
      addr_rq <= addr[pick];
      size_rq <= size[pick];
    end else if (busy_q) begin
      if (mem_ready) busy_q <= 1'b0;
      if (hit[ch_q]) kill_q <= 1'b1;
    end
  end

  assign mem_req   = busy_q;
  assign mem_addr  = addr_rq;
  assign mem_size  = size_rq;
  assign push      = accept;
  assign push_data = zext(mem_rdata, size_rq);
  assign req_ch    = ch_q;

  always_comb begin
    for (int i = 0; i < NCH; i++)
      done[i] = accept && (ch_q == CHW'(i));
  end

endmodule

// File: rtl/nbrd_fifo.sv
module nbrd_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    bump = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign do_pop  = pop && (level_q != '0);
  assign do_push = push && ((level_q < LW'(DEPTH)) || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      level_q <= level_q + LW'(1);
      else if (do_pop && !do_push) level_q <= level_q - LW'(1);
    end
  end

  assign dout  = store[rd_ptr];
  assign level = level_q;

endmodule

// File: rtl/nbrd_engine.sv
module nbrd_engine
  import nbrd_pkg::*;
#(
  parameter int AW    = 29,
  parameter int CW    = 12,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_ch,
  input  logic [1:0]    cfg_size,
  input  logic [AW-1:0] cfg_addr,
  input  logic          cnt_we,
  input  logic          cnt_ch,
  input  logic [CW-1:0] cnt_val,
  output logic [CW-1:0] cnt0_left,
  output logic [CW-1:0] cnt1_left,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  input  logic          fifo_pop,
  output logic [31:0]   fifo_data,
  output logic [LW-1:0] fifo_level
);

  logic [CW-1:0]  left_w [NCH];
  logic [AW-1:0]  addr_w [NCH];
  logic [1:0]     size_w [NCH];
  logic [NCH-1:0] hit_w, done_w, cfg_hit_w, cnt_hit_w;
  logic           push_w;
  logic [DW-1:0]  push_data_w;
  logic [$clog2(NCH)-1:0] req_ch_w;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign cfg_hit_w[g] = cfg_we && (cfg_ch == 1'(g));
    assign cnt_hit_w[g] = cnt_we && (cnt_ch == 1'(g));
    assign hit_w[g]     = cfg_hit_w[g] || cnt_hit_w[g];

    nbrd_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .cfg_hit   (cfg_hit_w[g]),
      .cfg_size  (cfg_size),
      .cfg_addr  (cfg_addr),
      .cnt_hit   (cnt_hit_w[g]),
      .cnt_val   (cnt_val),
      .item_done (done_w[g]),
      .size_q    (size_w[g]),
      .addr_q    (addr_w[g]),
      .left_q    (left_w[g])
    );
  end

  nbrd_issue #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .LW(LW)) u_issue (
    .clk        (clk),
    .rst        (rst),
    .left       (left_w),
    .addr       (addr_w),
    .size       (size_w),
    .hit        (hit_w),
    .fifo_level (fifo_level),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .push       (push_w),
    .push_data  (push_data_w),
    .done       (done_w),
    .req_ch     (req_ch_w)
  );

  nbrd_fifo #(.DEPTH(DEPTH), .W(DW), .LW(LW)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push_w),
    .din   (push_data_w),
    .pop   (fifo_pop),
    .dout  (fifo_data),
    .level (fifo_level)
  );

  assign cnt0_left = left_w[0];
  assign cnt1_left = left_w[1];

endmodule

// File: rtl/nbrd_engine_chk.sv
module nbrd_engine_chk #(
  parameter int AW    = 29,
  parameter int CW    = 12,
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cnt_we,
  input logic          cnt_ch,
  input logic [CW-1:0] cnt_val,
  input logic [CW-1:0] cnt0_left,
  input logic [CW-1:0] cnt1_left,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          fifo_pop,
  input logic [LW-1:0] fifo_level,
  input logic          req_ch
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(fifo_level) < LW'(DEPTH));

  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(DEPTH));

  // R10
  pop_level_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop && fifo_level != '0 && !(mem_req && mem_ready)
    |=> fifo_level == $past(fifo_level) - LW'(1));

  // R7
  cancel0_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_we && !cnt_ch && cnt_val == '0 |=> cnt0_left == '0);

  // R7
  cancel1_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_we && cnt_ch && cnt_val == '0 |=> cnt1_left == '0);

  // R8
  order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) && $past(cnt0_left) != '0 |-> req_ch == 1'b0);

endmodule

bind nbrd_engine nbrd_engine_chk #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_we     (cnt_we),
  .cnt_ch     (cnt_ch),
  .cnt_val    (cnt_val),
  .cnt0_left  (cnt0_left),
  .cnt1_left  (cnt1_left),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ready  (mem_ready),
  .fifo_pop   (fifo_pop),
  .fifo_level (fifo_level),
  .req_ch     (req_ch_w)
);

// File: tb/tb_nbrd_engine.sv
`timescale 1ns/1ps
module tb_nbrd_engine;

  localparam int AW = 29, CW = 12, DEPTH = 8, LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          cfg_we = 0, cfg_ch = 0, cnt_we = 0, cnt_ch = 0;
  logic [1:0]    cfg_size = 0;
  logic [AW-1:0] cfg_addr = 0;
  logic [CW-1:0] cnt_val = 0;
  logic [CW-1:0] cnt0_left, cnt1_left;
  logic          mem_req, mem_ready = 0, fifo_pop = 0;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [31:0]   mem_rdata = 0, fifo_data;
  logic [LW-1:0] fifo_level;

  nbrd_engine #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_size(cfg_size),
    .cfg_addr(cfg_addr), .cnt_we(cnt_we), .cnt_ch(cnt_ch), .cnt_val(cnt_val),
    .cnt0_left(cnt0_left), .cnt1_left(cnt1_left), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .fifo_pop(fifo_pop), .fifo_data(fifo_data),
    .fifo_level(fifo_level)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int lat = 0, force_cyc = -1, waited = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mdl(input logic [AW-1:0] a);
    return ({3'b0, a} * 32'h9E3779B1) ^ 32'hC3A55A3C;
  endfunction

  function automatic logic [31:0] zx(input logic [31:0] d, input int sz);
    if (sz == 0) return {24'b0, d[7:0]};
    if (sz == 1) return {16'b0, d[15:0]};
    return d;
  endfunction

  // Device model: answers after lat waiting negedges, or at a forced cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (force_cyc == cyc || (lat >= 0 && waited >= lat)) begin
          mem_ready = 1'b1;
          mem_rdata = mdl(mem_addr);
          waited = 0;
        end else begin
          mem_ready = 1'b0;
          waited++;
        end
      end else begin
        mem_ready = 1'b0;
        waited = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_cfg(input int ch, input int sz, input logic [AW-1:0] a);
    cfg_we = 1; cfg_ch = 1'(ch); cfg_size = 2'(sz); cfg_addr = a;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_cnt(input int ch, input int n);
    cnt_we = 1; cnt_ch = 1'(ch); cnt_val = CW'(n);
    @(negedge clk);
    cnt_we = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (cnt0_left == 0 && cnt1_left == 0 && !mem_req) break;
      @(negedge clk);
    end
  endtask

  task automatic pop_exp(input string tag, input logic [31:0] exp);
    for (int i = 0; i < 3000; i++) begin
      if (fifo_level != 0) break;
      @(negedge clk);
    end
    chk(tag, fifo_data, exp);
    fifo_pop = 1;
    @(negedge clk);
    fifo_pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 cnt0", 32'(cnt0_left), 0);
    chk("R1 cnt1", 32'(cnt1_left), 0);
    chk("R1 level", 32'(fifo_level), 0);
    chk("R1 req", 32'(mem_req), 0);
  endtask

  task automatic t_basic();
    lat = 0;
    do_cfg(0, 2, 29'h100);
    do_cnt(0, 3);
    chk("R2 count loaded", 32'(cnt0_left), 3);
    wait_idle();
    chk("R10 level after run", 32'(fifo_level), 3);
    chk("R2 count drained", 32'(cnt0_left), 0);
    for (int i = 0; i < 3; i++) pop_exp("R2 R10 data", mdl(29'h100 + 29'(4 * i)));
    chk("R10 level empty", 32'(fifo_level), 0);
    fifo_pop = 1; @(negedge clk); fifo_pop = 0;
    chk("R10 pop of empty ignored", 32'(fifo_level), 0);
  endtask

  task automatic t_sizes();
    lat = 1;
    do_cfg(1, 0, 29'h7);
    do_cnt(1, 2);
    pop_exp("R3 R4 byte0", zx(mdl(29'h7), 0));
    pop_exp("R3 R4 byte1", zx(mdl(29'h8), 0));
    do_cfg(1, 1, 29'h20);
    do_cnt(1, 2);
    pop_exp("R3 R4 half0", zx(mdl(29'h20), 1));
    pop_exp("R3 R4 half1", zx(mdl(29'h22), 1));
    do_cnt(1, 1);
    pop_exp("R6 sticky continue", zx(mdl(29'h24), 1));
    do_cfg(0, 1, 29'h1FFFFFFE);
    do_cnt(0, 2);
    pop_exp("R3 top address", zx(mdl(29'h1FFFFFFE), 1));
    pop_exp("R3 wrap to zero", zx(mdl(29'h0), 1));
    do_cnt(0, 1);
    pop_exp("R6 after wrap", zx(mdl(29'h2), 1));
    do_cfg(0, 3, 29'h10);
    do_cnt(0, 2);
    pop_exp("R3 code3 word0", mdl(29'h10));
    pop_exp("R3 code3 word1", mdl(29'h14));
    wait_idle();
  endtask

  task automatic t_full();
    lat = 0;
    do_cfg(0, 2, 29'h400);
    do_cnt(0, 12);
    repeat (60) @(negedge clk);
    chk("R5 level at full", 32'(fifo_level), DEPTH);
    chk("R5 count held", 32'(cnt0_left), 4);
    chk("R5 no request when full", 32'(mem_req), 0);
    pop_exp("R5 R10 head", mdl(29'h400));
    repeat (6) @(negedge clk);
    chk("R5 resumed refill", 32'(fifo_level), DEPTH);
    chk("R5 resumed count", 32'(cnt0_left), 3);
    for (int i = 1; i < 12; i++) pop_exp("R5 R10 drain", mdl(29'h400 + 29'(4 * i)));
    wait_idle();
    chk("R5 run completed", 32'(cnt0_left), 0);
  endtask

  task automatic t_priority();
    lat = 2;
    do_cfg(0, 2, 29'h1000);
    do_cfg(1, 2, 29'h2000);
    do_cnt(0, 3);
    do_cnt(1, 2);
    wait_idle();
    for (int i = 0; i < 3; i++) pop_exp("R8 ch0 first", mdl(29'h1000 + 29'(4 * i)));
    for (int i = 0; i < 2; i++) pop_exp("R8 ch1 after", mdl(29'h2000 + 29'(4 * i)));
  endtask

  task automatic t_cancel();
    lat = 3;
    do_cfg(0, 2, 29'h3000);
    do_cnt(0, 100);
    for (int i = 0; i < 3000; i++) begin
      if (fifo_level == 2) break;
      @(negedge clk);
    end
    do_cnt(0, 0);
    chk("R7 count cleared", 32'(cnt0_left), 0);
    repeat (20) @(negedge clk);
    chk("R7 no request", 32'(mem_req), 0);
    chk("R7 level frozen", 32'(fifo_level), 2);
    pop_exp("R7 kept item0", mdl(29'h3000));
    pop_exp("R7 kept item1", mdl(29'h3004));
    do_cnt(0, 1);
    pop_exp("R6 resume after cancel", mdl(29'h3008));
    wait_idle();
  endtask

  task automatic t_collide();
    lat = -1;
    do_cfg(1, 2, 29'h5000);
    do_cnt(1, 2);
    for (int i = 0; i < 100; i++) begin
      if (mem_req) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R11 stalled address", {31'b0, mem_req} + 32'(mem_addr), 32'h5001);
    force_cyc = cyc + 1;
    @(negedge clk);
    cnt_we = 1; cnt_ch = 1; cnt_val = 5;
    @(negedge clk);
    cnt_we = 0;
    force_cyc = -1;
    chk("R9 response discarded", 32'(fifo_level), 0);
    chk("R9 count takes write", 32'(cnt1_left), 5);
    lat = 0;
    wait_idle();
    for (int i = 0; i < 5; i++) pop_exp("R9 refetch order", mdl(29'h5000 + 29'(4 * i)));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sizes();
    t_full();
    t_priority();
    t_cancel();
    t_collide();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

endmodule